// File: doc/BRIEF.md
# Splittable Compare-Match Timer

This block is a 16-bit up-counter with output compare that software can also run as two separate 8-bit timers, a high half and a low half. Each half owns a compare register, a compare-match flag, an overflow flag, a clear-on-match option and a toggle output whose starting level software sets while the timer is stopped. In 16-bit mode the low half counts every count enable and the high half advances only on the low half's wrap. In that mode a match needs all sixteen bits to equal the joined compare value, and only the high half's output and flags respond.

A prescaler turns the system clock into a count enable at one of three division rates. A fourth choice divides an external slow tick, a single-cycle pulse from the watch clock that is already synchronous to the system clock, by four. The prescaler restarts from zero whenever counting is off, so the phase of the first count enable is fixed by the write that starts the timer. Software reaches eight byte registers over a synchronous write port with a combinational read port. Two level interrupt requests, one per half, are raised when an enabled flag is set.

Top module: `split_cmp_timer`

## Requirements
- R1: After reset both counter halves, all four flags, the interrupt enables, both outputs and the control register are zero, so the rate is divide-by-32, mode is 16-bit and counting is off. Both compare registers read 0xFF.
- R2: Control address 0 holds rate in bits [1:0] (0 = clk/32, 1 = clk/16, 2 = clk/4, 3 = slow tick/4), split in bit 2, run in bit 3, hold in bit 4, clear-on-match for high in bit 5 and low in bit 6. Counting is on when run is 1 and hold is 0. A run of k clock edges counted from the starting write edge up to and including the stopping write edge gives floor(k/D) count enables for divide rate D, and floor(t/4) for t slow ticks.
- R3: In 16-bit mode the high half (address 5) increments only on a count enable where the low half (address 4) wraps from 0xFF.
- R4: In 8-bit mode (split = 1) both halves take every count enable independently.
- R5: On a count enable where a half equals its compare register (low at address 6, high at address 7), that half's match flag is set and its output toggles. In 16-bit mode the full 16-bit value must match, and only the high flag and high output react.
- R6: With clear-on-match enabled, the matching count enable loads zero in place of incrementing and no overflow flag is set for it. In 16-bit mode the high-half bit clears both halves.
- R7: A count enable that steps a half, or the full 16-bit count in 16-bit mode, past all-ones sets that half's overflow flag.
- R8: Status address 2 holds high match (bit 0), high overflow (bit 1), low match (bit 2) and low overflow (bit 3). A write clears each flag whose written bit is 0 and leaves flags written with 1 unchanged.
- R9: Address 1 bits 0 (high) and 1 (low) load both outputs at once when written while counting is off. The same write while counting is on has no effect. A read of address 1 returns the current outputs.
- R10: The high interrupt is set when status bit 0 or 1 is set together with the same bit of the enable register at address 3. The low interrupt does the same with bits 2 and 3.
- R11: While hold is set the counter keeps its value and all register contents are kept. Clearing hold resumes counting from that value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| watch_tick | input | 1 | Single-cycle slow-clock tick, synchronous to clk |
| out_hi | output | 1 | High-half toggle output |
| out_lo | output | 1 | Low-half toggle output |
| irq_hi | output | 1 | High-half interrupt request (level) |
| irq_lo | output | 1 | Low-half interrupt request (level) |

## Verification
Writes take effect at the clock edge that samples them. Counter, flag and output changes land on the edge of the count enable that causes them. The read port follows the registers with no delay. The prescaler restarts when counting turns on, so the first enable falls on edge D after the starting write, and the bench stops the timer with a second write placed exactly k edges later. The bench samples only while the timer is stopped, on the falling edge, one nanosecond after setting the read address. Every expected count, flag set and toggle parity is therefore fixed by k and the compare values alone.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
// Package: shared register map, rate codes and control layout of the timer.
// Assumes an 8-bit register bus.
package tmr_pkg;
    localparam int REG_W = 8;

    typedef enum logic [2:0] {
        A_CTRL = 3'd0,
        A_OUT  = 3'd1,
        A_STAT = 3'd2,
        A_IEN  = 3'd3,
        A_CNTL = 3'd4,
        A_CNTH = 3'd5,
        A_CMPL = 3'd6,
        A_CMPH = 3'd7
    } reg_addr_e;

    typedef enum logic [1:0] {
        RATE_D32   = 2'd0,
        RATE_D16   = 2'd1,
        RATE_D4    = 2'd2,
        RATE_WATCH = 2'd3
    } rate_e;

    typedef struct packed {
        logic  clr_lo;
        logic  clr_hi;
        logic  hold;
        logic  run;
        logic  split;
        rate_e rate;
    } ctrl_t;

    localparam int ST_CMP_HI = 0;
    localparam int ST_OVF_HI = 1;
    localparam int ST_CMP_LO = 2;
    localparam int ST_OVF_LO = 3;
endpackage

// File: rtl/tmr_prescaler.sv
`timescale 1ns/1ps
// Module: tmr_prescaler
// Produces a single-cycle count enable at the selected rate. The divide counters
// restart from zero while counting is off, so the first enable lands DIV edges
// after counting starts. Assumes power-of-two divisors and that watch_tick is a
// one-cycle pulse already synchronous to clk.
module tmr_prescaler
    import tmr_pkg::*;
#(
    parameter int DIV_A     = 32,
    parameter int DIV_B     = 16,
    parameter int DIV_C     = 4,
    parameter int WATCH_DIV = 4
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  active,
    input  rate_e rate,
    input  logic  watch_tick,
    output logic  ce
);
    localparam int PRE_W = $clog2(DIV_A);
    localparam int WC_W  = (WATCH_DIV > 2) ? $clog2(WATCH_DIV) : 1;
    localparam logic [PRE_W-1:0] MASK_A = PRE_W'(DIV_A - 1);
    localparam logic [PRE_W-1:0] MASK_B = PRE_W'(DIV_B - 1);
    localparam logic [PRE_W-1:0] MASK_C = PRE_W'(DIV_C - 1);
    localparam logic [WC_W-1:0]  W_LAST = WC_W'(WATCH_DIV - 1);

    logic [PRE_W-1:0] pre;
    logic [WC_W-1:0]  wcnt;

    // System-clock divide counter, held at zero while idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) pre <= '0;
        else                   pre <= pre + 1'b1;
    end

    // Slow-tick divide counter, held at zero while idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) wcnt <= '0;
        else if (watch_tick)   wcnt <= wcnt + 1'b1;
    end

    // Rate selection into one count-enable pulse.
    always_comb begin
        unique case (rate)
            RATE_D32:   ce = active && ((pre & MASK_A) == MASK_A);
            RATE_D16:   ce = active && ((pre & MASK_B) == MASK_B);
            RATE_D4:    ce = active && ((pre & MASK_C) == MASK_C);
            RATE_WATCH: ce = active && watch_tick && (wcnt == W_LAST);
            default:    ce = 1'b0;
        endcase
    end
endmodule

// File: rtl/tmr_half.sv
`timescale 1ns/1ps
// Module: tmr_half
// One counter half plus its toggle output. The caller decides when to step,
// clear, toggle or load; clear has priority over step, load over toggle.
module tmr_half #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    input  logic         clear,
    input  logic         load_lvl,
    input  logic         lvl,
    input  logic         toggle,
    output logic [W-1:0] cnt,
    output logic         pin
);
    // Counter: zero on clear, +1 on step.
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt <= '0;
        else if (clear) cnt <= '0;
        else if (step)  cnt <= cnt + 1'b1;
    end

    // Output level: software load, otherwise toggle on match.
    always_ff @(posedge clk) begin
        if (!rst_n)        pin <= 1'b0;
        else if (load_lvl) pin <= lvl;
        else if (toggle)   pin <= ~pin;
    end
endmodule

// File: rtl/split_cmp_timer.sv
`timescale 1ns/1ps
// Module: split_cmp_timer
// 16-bit compare-match timer that splits into two 8-bit timers. Holds the
// register file, the compare/overflow event logic for both modes and the
// interrupt gating. Assumes HALF_W equals the register bus width (8).
module split_cmp_timer
    import tmr_pkg::*;
#(
    parameter int HALF_W    = REG_W,
    parameter int DIV_A     = 32,
    parameter int DIV_B     = 16,
    parameter int DIV_C     = 4,
    parameter int WATCH_DIV = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        addr,
    input  logic [HALF_W-1:0] wdata,
    output logic [HALF_W-1:0] rdata,
    input  logic              watch_tick,
    output logic              out_hi,
    output logic              out_lo,
    output logic              irq_hi,
    output logic              irq_lo
);
    localparam int NH = 2;   // index 0 = low half, 1 = high half
    localparam logic [HALF_W-1:0] ALL1 = '1;

    ctrl_t             ctrl;
    logic [3:0]        stat, ien, stat_set;
    logic [HALF_W-1:0] cmp   [NH];
    logic [HALF_W-1:0] cnt   [NH];
    logic [NH-1:0]     pin, step, clr, tog, match, at_max;
    logic              active, ce, split, m16, clr16, load_out;
    logic              wr_ctrl, wr_out, wr_stat, wr_ien, wr_cmpl, wr_cmph;

    assign active  = ctrl.run && !ctrl.hold;
    assign split   = ctrl.split;
    assign wr_ctrl = wr_en && (addr == A_CTRL);
    assign wr_out  = wr_en && (addr == A_OUT);
    assign wr_stat = wr_en && (addr == A_STAT);
    assign wr_ien  = wr_en && (addr == A_IEN);
    assign wr_cmpl = wr_en && (addr == A_CMPL);
    assign wr_cmph = wr_en && (addr == A_CMPH);
    assign load_out = wr_out && !active;

    tmr_prescaler #(
        .DIV_A(DIV_A), .DIV_B(DIV_B), .DIV_C(DIV_C), .WATCH_DIV(WATCH_DIV)
    ) u_pre (
        .clk(clk), .rst_n(rst_n), .active(active), .rate(ctrl.rate),
        .watch_tick(watch_tick), .ce(ce)
    );

    // One counter slice per half; compare and wrap detection per slice.
    for (genvar h = 0; h < NH; h++) begin : g_half
        assign match[h]  = (cnt[h] == cmp[h]);
        assign at_max[h] = (cnt[h] == ALL1);
        tmr_half #(.W(HALF_W)) u_half (
            .clk(clk), .rst_n(rst_n), .step(step[h]), .clear(clr[h]),
            .load_lvl(load_out), .lvl(wdata[1-h]), .toggle(tog[h]),
            .cnt(cnt[h]), .pin(pin[h])
        );
    end

    assign m16   = match[0] && match[1];
    assign clr16 = ce && m16 && ctrl.clr_hi;

    // Count, clear, toggle and flag events for the selected mode.
    always_comb begin
        if (split) begin
            tog[0]  = ce && match[0];
            tog[1]  = ce && match[1];
            clr[0]  = tog[0] && ctrl.clr_lo;
            clr[1]  = tog[1] && ctrl.clr_hi;
            step[0] = ce && !clr[0];
            step[1] = ce && !clr[1];
            stat_set[ST_CMP_LO] = tog[0];
            stat_set[ST_OVF_LO] = step[0] && at_max[0];
            stat_set[ST_CMP_HI] = tog[1];
            stat_set[ST_OVF_HI] = step[1] && at_max[1];
        end else begin
            tog[0]  = 1'b0;
            tog[1]  = ce && m16;
            clr[0]  = clr16;
            clr[1]  = clr16;
            step[0] = ce && !clr16;
            step[1] = step[0] && at_max[0];
            stat_set[ST_CMP_LO] = 1'b0;
            stat_set[ST_OVF_LO] = 1'b0;
            stat_set[ST_CMP_HI] = tog[1];
            stat_set[ST_OVF_HI] = step[1] && at_max[1];
        end
    end

    // Control, enable and compare registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl   <= '0;
            ien    <= '0;
            cmp[0] <= '1;
            cmp[1] <= '1;
        end else begin
            if (wr_ctrl) ctrl   <= ctrl_t'(wdata[6:0]);
            if (wr_ien)  ien    <= wdata[3:0];
            if (wr_cmpl) cmp[0] <= wdata;
            if (wr_cmph) cmp[1] <= wdata;
        end
    end

    // Sticky flags: hardware sets, software clears by writing zero.
    always_ff @(posedge clk) begin
        if (!rst_n)       stat <= '0;
        else if (wr_stat) stat <= (stat & wdata[3:0]) | stat_set;
        else              stat <= stat | stat_set;
    end

    // Combinational read port.
    always_comb begin
        unique case (reg_addr_e'(addr))
            A_CTRL:  rdata = HALF_W'(ctrl);
            A_OUT:   rdata = HALF_W'({pin[0], pin[1]});
            A_STAT:  rdata = HALF_W'(stat);
            A_IEN:   rdata = HALF_W'(ien);
            A_CNTL:  rdata = cnt[0];
            A_CNTH:  rdata = cnt[1];
            A_CMPL:  rdata = cmp[0];
            A_CMPH:  rdata = cmp[1];
            default: rdata = '0;
        endcase
    end

    assign out_lo = pin[0];
    assign out_hi = pin[1];
    assign irq_hi = |(stat[ST_OVF_HI:ST_CMP_HI] & ien[ST_OVF_HI:ST_CMP_HI]);
    assign irq_lo = |(stat[ST_OVF_LO:ST_CMP_LO] & ien[ST_OVF_LO:ST_CMP_LO]);
endmodule

// File: rtl/tmr_checker.sv
`timescale 1ns/1ps
// Module: tmr_checker
// Temporal checks on the timer, bound into split_cmp_timer. Observes the
// register port, the halves and the flag state; drives nothing.
module tmr_checker
    import tmr_pkg::*;
#(
    parameter int HALF_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [2:0]        addr,
    input logic [HALF_W-1:0] wdata,
    input logic              active,
    input logic              split,
    input logic [HALF_W-1:0] cnt_lo,
    input logic [HALF_W-1:0] cnt_hi,
    input logic [3:0]        stat,
    input logic              irq_hi,
    input logic              irq_lo
);
    // Idle or held: the count does not move on the next edge.
    assert_idle_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> ($stable(cnt_lo) && $stable(cnt_hi)));

    // Each half only ever steps by one or returns to zero.
    assert_lo_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_lo != $past(cnt_lo)) |-> ((cnt_lo == $past(cnt_lo) + 1'b1) || (cnt_lo == '0)));
    assert_hi_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_hi != $past(cnt_hi)) |-> ((cnt_hi == $past(cnt_hi) + 1'b1) || (cnt_hi == '0)));

    // In 16-bit mode the low-half flags never rise.
    assert_lo_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!split && (stat[ST_OVF_LO:ST_CMP_LO] == 2'b00)) |=> (stat[ST_OVF_LO:ST_CMP_LO] == 2'b00));

    // A set flag survives unless written with zero.
    for (genvar i = 0; i < 4; i++) begin : g_sticky
        assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (stat[i] && !(wr_en && (addr == A_STAT) && !wdata[i])) |=> stat[i]);
    end

    // A request needs a set flag of its own half.
    assert_irq_hi_src_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_hi |-> (stat[ST_OVF_HI:ST_CMP_HI] != 2'b00));
    assert_irq_lo_src_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_lo |-> (stat[ST_OVF_LO:ST_CMP_LO] != 2'b00));
endmodule

bind split_cmp_timer tmr_checker #(.HALF_W(HALF_W)) u_tmr_checker (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .active(active), .split(split), .cnt_lo(cnt[0]), .cnt_hi(cnt[1]),
    .stat(stat), .irq_hi(irq_hi), .irq_lo(irq_lo)
);

// File: tb/test_split_cmp_timer.sv
`timescale 1ns/1ps
// Bench: rate/mode vector table, then directed tests for reset and corner cases.
module test_split_cmp_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] addr = 3'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       watch_tick = 1'b0;
    logic       out_hi, out_lo, irq_hi, irq_lo;
    int         n_chk = 0;
    int         n_bad = 0;
    logic [7:0] v;

    always #10 clk = ~clk;   // 50 MHz

    split_cmp_timer i_split_cmp_timer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .watch_tick(watch_tick), .out_hi(out_hi), .out_lo(out_lo),
        .irq_hi(irq_hi), .irq_lo(irq_lo)
    );

    typedef struct packed {
        logic [1:0]  rate;
        logic        split;
        logic [15:0] k;
        logic [7:0]  lo;
        logic [7:0]  hi;
        logic [3:0]  st;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 1'b0, 16'd100,  8'h03, 8'h00, 4'h0},   // R2 /32
        '{2'd1, 1'b0, 16'd100,  8'h06, 8'h00, 4'h0},   // R2 /16
        '{2'd2, 1'b0, 16'd100,  8'h19, 8'h00, 4'h0},   // R2 /4
        '{2'd2, 1'b0, 16'd3,    8'h00, 8'h00, 4'h0},   // R2 below one period
        '{2'd1, 1'b0, 16'd16,   8'h01, 8'h00, 4'h0},   // R2 exactly one period
        '{2'd2, 1'b0, 16'd1100, 8'h13, 8'h01, 4'h0},   // R3 carry into high
        '{2'd2, 1'b1, 16'd1100, 8'h13, 8'h13, 4'hF},   // R4 R5 R7 split wrap
        '{2'd0, 1'b1, 16'd64,   8'h02, 8'h02, 4'h0}    // R4 split /32
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Start with ctrl value c_run, stop with c_stop exactly k edges later.
    task automatic run_for(input logic [7:0] c_run, input logic [7:0] c_stop, input int k);
        wr(3'd0, c_run);
        repeat (k - 1) @(posedge clk);
        wr(3'd0, c_stop);
    endtask

    initial begin
        #(20 * 200000);
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        do_reset();
        // R1 reset state
        rd(3'd0, v); chk("R1 ctrl", v, 8'h00);
        rd(3'd1, v); chk("R1 outputs", v, 8'h00);
        rd(3'd2, v); chk("R1 status", v, 8'h00);
        rd(3'd4, v); chk("R1 cnt_lo", v, 8'h00);
        rd(3'd5, v); chk("R1 cnt_hi", v, 8'h00);
        rd(3'd6, v); chk("R1 cmp_lo", v, 8'hFF);
        rd(3'd7, v); chk("R1 cmp_hi", v, 8'hFF);
        chk("R1 irq pins", {6'd0, irq_hi, irq_lo}, 8'h00);

        // Vector table: rate and mode sweep
        for (int i = 0; i < NV; i++) begin
            do_reset();
            run_for({4'd0, 1'b1, VECS[i].split, VECS[i].rate},
                    {5'd0, VECS[i].split, VECS[i].rate}, int'(VECS[i].k));
            rd(3'd4, v); chk("R2 R3 R4 vector cnt_lo", v, VECS[i].lo);
            rd(3'd5, v); chk("R2 R3 R4 vector cnt_hi", v, VECS[i].hi);
            rd(3'd2, v); chk("R5 R7 vector status", v, {4'd0, VECS[i].st});
        end

        // R2 slow tick divided by four: 10 ticks give 2 counts
        do_reset();
        wr(3'd0, 8'h0B);
        for (int t = 0; t < 10; t++) begin
            @(negedge clk) watch_tick = 1'b1;
            @(negedge clk) watch_tick = 1'b0;
            repeat (2) @(posedge clk);
        end
        wr(3'd0, 8'h03);
        rd(3'd4, v); chk("R2 slow tick count", v, 8'h02);

        // R6 R5 R10 split clear-on-match on low half, cmp_lo = 3, 5 enables
        do_reset();
        wr(3'd6, 8'h03);
        wr(3'd3, 8'h0F);
        run_for(8'h4E, 8'h46, 20);
        rd(3'd4, v); chk("R6 low cleared then stepped", v, 8'h01);
        rd(3'd5, v); chk("R4 high independent", v, 8'h05);
        rd(3'd2, v); chk("R6 match without overflow", v, 8'h04);
        chk("R5 out_lo toggled", {7'd0, out_lo}, 8'h01);
        chk("R5 out_hi untouched", {7'd0, out_hi}, 8'h00);
        chk("R10 irq_lo raised", {7'd0, irq_lo}, 8'h01);
        chk("R10 irq_hi quiet", {7'd0, irq_hi}, 8'h00);
        // R8 write-one keeps, write-zero clears
        wr(3'd2, 8'hFF);
        rd(3'd2, v); chk("R8 write ones keeps", v, 8'h04);
        wr(3'd2, 8'h00);
        rd(3'd2, v); chk("R8 write zero clears", v, 8'h00);
        chk("R10 irq_lo drops", {7'd0, irq_lo}, 8'h00);

        // R5 R6 16-bit match at 0x0102 with clear, 262 enables
        do_reset();
        wr(3'd6, 8'h02);
        wr(3'd7, 8'h01);
        run_for(8'h2A, 8'h22, 1048);
        rd(3'd4, v); chk("R6 16-bit cnt_lo", v, 8'h03);
        rd(3'd5, v); chk("R6 16-bit cnt_hi", v, 8'h00);
        rd(3'd2, v); chk("R5 16-bit flags high only", v, 8'h01);
        chk("R5 16-bit out_hi toggled", {7'd0, out_hi}, 8'h01);
        chk("R5 16-bit out_lo quiet", {7'd0, out_lo}, 8'h00);

        // R9 output level load when stopped, ignored when running
        do_reset();
        wr(3'd1, 8'h03);
        rd(3'd1, v); chk("R9 load when stopped", v, 8'h03);
        chk("R9 pins loaded", {6'd0, out_lo, out_hi}, 8'h03);
        wr(3'd0, 8'h0A);
        wr(3'd1, 8'h00);
        rd(3'd1, v); chk("R9 ignored while running", v, 8'h03);
        wr(3'd0, 8'h02);

        // R11 hold freezes count and keeps registers
        do_reset();
        wr(3'd6, 8'h55);
        run_for(8'h0A, 8'h1A, 40);
        repeat (100) @(posedge clk);
        rd(3'd4, v); chk("R11 count frozen", v, 8'h0A);
        rd(3'd6, v); chk("R11 compare kept", v, 8'h55);
        run_for(8'h0A, 8'h02, 40);
        rd(3'd4, v); chk("R11 resumes", v, 8'h14);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule